// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one 16-bit timer channel with four general registers, named A, B, C and D. Software sets each register to work either as an output compare register or as an input capture register. The counter advances on rising edges of one count clock, picked from eight slow clock sources. The system clock samples that source and turns each rising edge into a one-cycle count tick.

A compare register sets, clears or toggles its own output pin when the counter matches it. A capture register stores the counter value on a chosen edge of its own input. Any one of the four registers can reset the counter, so the channel can produce periodic waveforms or measure pulse periods.

Registers C and D can be paired with A and B as buffers. In a buffered pair a capture moves the previous capture value into the buffer, and a compare match reloads the compare value from the buffer. Software uses a small word-wide register bus to set up the channel and read it, and clears the event flags by writing 1 to them.

Register addresses on the bus: 0 control, 1 to 4 mode of A to D, 5 counter, 6 to 9 general registers A to D, 10 flags. The read data is combinational on `bus_addr`. Unused upper bits read as 0. When more than one source updates a value on the same clock edge, this order applies:
- Counter: a bus write wins over a capture clear, and a capture clear wins over a count tick.
- General registers: capture and reload events win over bus writes.
- Flags: a new event wins over a write-1 clear.

Top module: `cct_timer_channel`

## Requirements
- R1: The control register field bits [2:0] selects one of eight count sources. Each rising edge of the selected source advances the counter by exactly one. Edges on the other sources do not change the counter.
- R2: A register in compare mode (mode bit 0 = 0) matches on a count tick during which the counter equals the register value. On a match, its output pin acts according to mode bits [2:1]: 0 = hold, 1 = drive 0, 2 = drive 1, 3 = toggle.
- R3: A register in capture mode (mode bit 0 = 1) loads the current counter value on the input edges picked by mode bits [2:1]: 1 = rising, 2 = falling, 3 = both. The other edge leaves the register unchanged.
- R4: The control register field bits [5:3] selects a clear source, where 1 to 4 name registers A to D and other values mean none. If the source has a compare match, the counter loads 0 in place of incrementing, so the period is the compare value plus one. If the source has a capture, the counter goes to 0.
- R5: With control bit 6 (pair A/C) or bit 7 (pair B/D) set, a capture on A or B moves the register's previous value into C or D on the same edge.
- R6: In a buffered pair, a compare match on A or B reloads that register from C or D.
- R7: Flag bits 0 to 3 set on a compare match or capture of A to D, whatever the pin action. Flag bit 4 sets when a count tick wraps the counter from 0xFFFF to 0.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. An event in the same cycle keeps the bit set.
- R9: After reset, the counter, all registers, the flags and the output pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_src | input | 8 | Count clock sources, asynchronous |
| cap_in | input | 4 | Capture inputs for A to D, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cmp_pin | output | 4 | Compare output pins for A to D |
| evt_flag | output | 5 | Event flags: bits 0 to 3 for A to D, bit 4 for overflow |

## Verification
The embedded properties check these rules on every cycle:
- Count ticks are isolated.
- The counter holds without a tick and advances by one on an ordinary tick.
- The counter goes to zero on a match-clear.
- The overflow flag sets on a wrap.
- A pin holds when it has no event and inverts on a toggle event.
- A capture stores the previous counter value.
- A write-1 clear takes effect.

Only the bench scenarios can show the end-to-end behaviour:
- The effect of the clock selection.
- The compare-plus-one period.
- Edge polarity selection through the synchronizers.
- The buffered capture history and compare reload.
- The capture-triggered clear.

// File: rtl/cct_pkg.sv
package cct_pkg;
   localparam int NUM_GR   = 4;
   localparam int NUM_PAIR = 2;
   localparam int ADDR_W   = 4;
   localparam int FLAG_W   = NUM_GR + 1;

   localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
   localparam logic [ADDR_W-1:0] A_MODE0 = 4'd1;
   localparam logic [ADDR_W-1:0] A_CNT   = 4'd5;
   localparam logic [ADDR_W-1:0] A_GR0   = 4'd6;
   localparam logic [ADDR_W-1:0] A_FLAG  = 4'd10;

   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_LOW    = 2'd1,
      ACT_HIGH   = 2'd2,
      ACT_TOGGLE = 2'd3
   } pin_act_e;

   typedef struct packed {
      logic [1:0] act;
      logic       is_cap;
   } gr_mode_t;
endpackage

// File: rtl/cct_clk_select.sv
module cct_clk_select #(
   parameter int NUM_SRC = 8,
   parameter int SEL_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic [SEL_W-1:0]   sel,
   output logic               tick
);
   if (NUM_SRC != (1 << SEL_W)) begin : g_bad_sel
      $error("cct_clk_select: NUM_SRC must equal 2**SEL_W");
   end

   logic [NUM_SRC-1:0] meta_q, sync_q;
   logic               prev_q;
   logic               cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         meta_q <= src;
         sync_q <= meta_q;
         prev_q <= cur;
      end
   end

   assign cur  = sync_q[sel];
   assign tick = cur & ~prev_q;

   p_tick_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick)
      else $error("count tick on two consecutive cycles");
endmodule

// File: rtl/cct_cap_detect.sv
module cct_cap_detect #(
   parameter int NUM_IN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] pin,
   output logic [NUM_IN-1:0] rise,
   output logic [NUM_IN-1:0] fall
);
   if (NUM_IN < 1) begin : g_bad_n
      $error("cct_cap_detect: NUM_IN must be positive");
   end

   for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      logic s1_q, s2_q, s3_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
         end else begin
            s1_q <= pin[i];
            s2_q <= s1_q;
            s3_q <= s2_q;
         end
      end
      assign rise[i] = s2_q & ~s3_q;
      assign fall[i] = ~s2_q & s3_q;

      p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
         rise[i] |=> !rise[i])
         else $error("rise pulse longer than one cycle");
   end
endmodule

// File: rtl/cct_pin_drive.sv
module cct_pin_drive (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       evt,
   input  logic [1:0] act,
   output logic       pin
);
   import cct_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin <= 1'b0;
      end else if (evt) begin
         case (pin_act_e'(act))
            ACT_LOW:    pin <= 1'b0;
            ACT_HIGH:   pin <= 1'b1;
            ACT_TOGGLE: pin <= ~pin;
            default:    pin <= pin;
         endcase
      end
   end

   p_pin_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !evt |=> $stable(pin))
      else $error("compare pin moved without a match");

   p_pin_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && act == 2'd3) |=> (pin != $past(pin)))
      else $error("toggle action did not invert the pin");
endmodule

// File: rtl/cct_timer_channel.sv
module cct_timer_channel #(
   parameter int CNT_W   = 16,
   parameter int NUM_SRC = 8,
   parameter int DATA_W  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC-1:0]         cnt_src,
   input  logic [cct_pkg::NUM_GR-1:0] cap_in,
   input  logic                       bus_wr,
   input  logic [cct_pkg::ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   output logic [cct_pkg::NUM_GR-1:0] cmp_pin,
   output logic [cct_pkg::FLAG_W-1:0] evt_flag
);
   import cct_pkg::*;

   localparam int SEL_W  = $clog2(NUM_SRC);
   localparam int CLR_W  = 3;
   localparam int CTRL_W = SEL_W + CLR_W + NUM_PAIR;
   localparam int CLR_LO = SEL_W;
   localparam int BUF_LO = SEL_W + CLR_W;

   if (CNT_W != DATA_W) begin : g_bad_w
      $error("cct_timer_channel: CNT_W must equal DATA_W");
   end
   if (CTRL_W > DATA_W) begin : g_bad_ctrl
      $error("cct_timer_channel: control field exceeds the data width");
   end

   // bus decode
   logic              wr_ctrl, wr_cnt, wr_flag;
   logic [NUM_GR-1:0] wr_mode, wr_gr;

   always_comb begin
      wr_ctrl = bus_wr && (bus_addr == A_CTRL);
      wr_cnt  = bus_wr && (bus_addr == A_CNT);
      wr_flag = bus_wr && (bus_addr == A_FLAG);
      for (int i = 0; i < NUM_GR; i++) begin
         wr_mode[i] = bus_wr && (bus_addr == A_MODE0 + ADDR_W'(i));
         wr_gr[i]   = bus_wr && (bus_addr == A_GR0 + ADDR_W'(i));
      end
   end

   // control and mode registers
   logic [CTRL_W-1:0] ctrl_q;
   gr_mode_t          mode_q [NUM_GR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= bus_wdata[CTRL_W-1:0];
      end
   end

   for (genvar i = 0; i < NUM_GR; i++) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q[i] <= '0;
         end else if (wr_mode[i]) begin
            mode_q[i] <= gr_mode_t'(bus_wdata[2:0]);
         end
      end
   end

   logic [SEL_W-1:0]    clk_sel;
   logic [CLR_W-1:0]    clr_sel;
   logic [NUM_PAIR-1:0] buf_en;
   assign clk_sel = ctrl_q[SEL_W-1:0];
   assign clr_sel = ctrl_q[CLR_LO +: CLR_W];
   assign buf_en  = ctrl_q[BUF_LO +: NUM_PAIR];

   // count tick and capture edges
   logic              tick;
   logic [NUM_GR-1:0] cap_rise, cap_fall;

   cct_clk_select #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_clk_sel (
      .clk(clk), .rst_n(rst_n), .src(cnt_src), .sel(clk_sel), .tick(tick));

   cct_cap_detect #(.NUM_IN(NUM_GR)) u_cap_det (
      .clk(clk), .rst_n(rst_n), .pin(cap_in), .rise(cap_rise), .fall(cap_fall));

   // events per general register
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  gr_val [NUM_GR];
   logic [NUM_GR-1:0] slot_on, cap_evt, cmp_evt;

   for (genvar i = 0; i < NUM_GR; i++) begin : g_evt
      if (i < NUM_PAIR) begin : g_main
         assign slot_on[i] = 1'b1;
      end else begin : g_buf
         assign slot_on[i] = ~buf_en[i-NUM_PAIR];
      end
      assign cap_evt[i] = slot_on[i] & mode_q[i].is_cap &
                          ((mode_q[i].act[0] & cap_rise[i]) |
                           (mode_q[i].act[1] & cap_fall[i]));
      assign cmp_evt[i] = slot_on[i] & ~mode_q[i].is_cap & tick &
                          (cnt_q == gr_val[i]);
   end

   // clear source selection
   logic match_clr, cap_clr;
   always_comb begin
      match_clr = 1'b0;
      cap_clr   = 1'b0;
      for (int i = 0; i < NUM_GR; i++) begin
         if (clr_sel == CLR_W'(i + 1)) begin
            match_clr = cmp_evt[i];
            cap_clr   = cap_evt[i];
         end
      end
   end

   // counter
   logic wrap;
   assign wrap = tick && !match_clr && !cap_clr && !wr_cnt && (cnt_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_cnt) begin
         cnt_q <= bus_wdata[CNT_W-1:0];
      end else if (cap_clr) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= match_clr ? '0 : cnt_q + 1'b1;
      end
   end

   // general registers
   for (genvar i = 0; i < NUM_GR; i++) begin : g_gr
      logic [CNT_W-1:0] gr_q;
      if (i < NUM_PAIR) begin : g_main
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gr_q <= '0;
            end else if (cap_evt[i]) begin
               gr_q <= cnt_q;
            end else if (cmp_evt[i] && buf_en[i]) begin
               gr_q <= gr_val[i+NUM_PAIR];
            end else if (wr_gr[i]) begin
               gr_q <= bus_wdata[CNT_W-1:0];
            end
         end

         p_capture_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cap_evt[i] |=> (gr_q == $past(cnt_q)))
            else $error("capture did not store the counter value");
      end else begin : g_buf
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gr_q <= '0;
            end else if (buf_en[i-NUM_PAIR] && cap_evt[i-NUM_PAIR]) begin
               gr_q <= gr_val[i-NUM_PAIR];
            end else if (cap_evt[i]) begin
               gr_q <= cnt_q;
            end else if (wr_gr[i]) begin
               gr_q <= bus_wdata[CNT_W-1:0];
            end
         end
      end
      assign gr_val[i] = gr_q;
   end

   // output pins
   for (genvar i = 0; i < NUM_GR; i++) begin : g_pin
      cct_pin_drive u_pin (
         .clk(clk), .rst_n(rst_n), .evt(cmp_evt[i]),
         .act(mode_q[i].act), .pin(cmp_pin[i]));
   end

   // flags
   logic [FLAG_W-1:0] flag_set, flag_clr, flag_q;
   assign flag_set = {wrap, cap_evt | cmp_evt};
   assign flag_clr = wr_flag ? bus_wdata[FLAG_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else begin
         flag_q <= (flag_q & ~flag_clr) | flag_set;
      end
   end
   assign evt_flag = flag_q;

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CTRL) begin
         bus_rdata = DATA_W'(ctrl_q);
      end else if (bus_addr == A_CNT) begin
         bus_rdata = cnt_q;
      end else if (bus_addr == A_FLAG) begin
         bus_rdata = DATA_W'(flag_q);
      end
      for (int i = 0; i < NUM_GR; i++) begin
         if (bus_addr == A_MODE0 + ADDR_W'(i)) begin
            bus_rdata = DATA_W'(mode_q[i]);
         end
         if (bus_addr == A_GR0 + ADDR_W'(i)) begin
            bus_rdata = gr_val[i];
         end
      end
   end

   // properties
   p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_cnt && !cap_clr) |=> $stable(cnt_q))
      else $error("counter moved without a tick");

   p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_cnt && !cap_clr && !match_clr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1)))
      else $error("counter did not step by one");

   p_match_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (match_clr && !wr_cnt) |=> (cnt_q == '0))
      else $error("match clear did not zero the counter");

   p_overflow_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (evt_flag[FLAG_W-1] && cnt_q == '0))
      else $error("wrap did not raise the overflow flag");

   p_flag_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && bus_wdata[FLAG_W-1] && !wrap) |=> !evt_flag[FLAG_W-1])
      else $error("write-one clear failed on overflow flag");
endmodule

// File: tb/cct_timer_channel_tb.sv
module cct_timer_channel_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cnt_src = '0;
   logic [3:0]  cap_in = '0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [3:0]  cmp_pin;
   logic [4:0]  evt_flag;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cct_timer_channel u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_src(cnt_src), .cap_in(cap_in),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cmp_pin(cmp_pin), .evt_flag(evt_flag));

   // act[43:42] gr[41:26] pulses[25:18] pin[17] cnt[16:1] flag[0]
   localparam int NV = 6;
   localparam logic [43:0] VEC [NV] = '{
      {2'd2, 16'd3, 8'd5, 1'b1, 16'd5, 1'b1},
      {2'd1, 16'd2, 8'd2, 1'b1, 16'd2, 1'b0},
      {2'd1, 16'd2, 8'd3, 1'b0, 16'd3, 1'b1},
      {2'd3, 16'd0, 8'd1, 1'b1, 16'd1, 1'b1},
      {2'd3, 16'd1, 8'd4, 1'b0, 16'd4, 1'b1},
      {2'd0, 16'd0, 8'd3, 1'b0, 16'd3, 1'b1}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse(input int k, input int n);
      for (int p = 0; p < n; p++) begin
         @(negedge clk); cnt_src[k] = 1'b1;
         repeat (3) @(negedge clk);
         cnt_src[k] = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic cap(input int k, input logic v);
      @(negedge clk); cap_in[k] = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset state
      rd(4'd5, d);  check("R9 counter", d, 0);
      rd(4'd10, d); check("R9 flags", d, 0);
      rd(4'd6, d);  check("R9 reg A", d, 0);
      check("R9 pins", cmp_pin, 0);

      // R2 R7 table of compare vectors on register A, source 0
      for (int v = 0; v < NV; v++) begin
         wr(4'd1, {13'd0, VEC[v][43:42], 1'b0});
         wr(4'd6, VEC[v][41:26]);
         wr(4'd5, 16'd0);
         wr(4'd10, 16'h1f);
         pulse(0, int'(VEC[v][25:18]));
         check("R2 pin A", cmp_pin[0], VEC[v][17]);
         rd(4'd5, d); check("R1 count", d, VEC[v][16:1]);
         check("R7 flag A", evt_flag[0], VEC[v][0]);
      end

      // R4 clear on compare match: period = 3
      wr(4'd0, 16'h0008);
      wr(4'd1, 16'h0004);
      wr(4'd6, 16'd2);
      wr(4'd5, 16'd0);
      pulse(0, 7);
      rd(4'd5, d); check("R4 match clear count", d, 1);
      check("R2 pin high", cmp_pin[0], 1);

      // R1 clock select
      wr(4'd0, 16'h0005);
      wr(4'd5, 16'd0);
      pulse(2, 3);
      rd(4'd5, d); check("R1 unselected ignored", d, 0);
      pulse(5, 2);
      rd(4'd5, d); check("R1 selected counts", d, 2);

      // R3 capture edges
      wr(4'd0, 16'h0000);
      wr(4'd10, 16'h1f);
      wr(4'd2, 16'h0003);
      wr(4'd5, 16'd100);
      cap(1, 1'b1);
      rd(4'd7, d); check("R3 rising capture", d, 100);
      check("R7 flag B", evt_flag[1], 1);
      wr(4'd5, 16'd200);
      cap(1, 1'b0);
      rd(4'd7, d); check("R3 falling ignored", d, 100);
      wr(4'd3, 16'h0007);
      wr(4'd5, 16'd300);
      cap(2, 1'b1);
      rd(4'd8, d); check("R3 both rise", d, 300);
      wr(4'd5, 16'd301);
      cap(2, 1'b0);
      rd(4'd8, d); check("R3 both fall", d, 301);
      wr(4'd4, 16'h0005);
      wr(4'd5, 16'd400);
      cap(3, 1'b1);
      rd(4'd9, d); check("R3 rise ignored", d, 0);
      cap(3, 1'b0);
      rd(4'd9, d); check("R3 falling capture", d, 400);

      // R5 buffered capture on B/D
      wr(4'd0, 16'h0080);
      wr(4'd5, 16'd10);
      cap(1, 1'b1);
      rd(4'd7, d); check("R5 B new", d, 10);
      rd(4'd9, d); check("R5 D old", d, 100);
      cap(1, 1'b0);
      wr(4'd5, 16'd20);
      cap(1, 1'b1);
      rd(4'd7, d); check("R5 B second", d, 20);
      rd(4'd9, d); check("R5 D history", d, 10);

      // R6 buffered compare reload on A/C
      wr(4'd0, 16'h0040);
      wr(4'd1, 16'h0000);
      wr(4'd6, 16'd1);
      wr(4'd8, 16'd4);
      wr(4'd5, 16'd0);
      wr(4'd10, 16'h1f);
      pulse(0, 2);
      rd(4'd6, d); check("R6 A reloaded", d, 4);
      check("R6 match flag", evt_flag[0], 1);

      // R4 clear on capture of B
      wr(4'd0, 16'h0010);
      cap(1, 1'b0);
      wr(4'd5, 16'd50);
      cap(1, 1'b1);
      rd(4'd5, d); check("R4 capture clear", d, 0);
      rd(4'd7, d); check("R4 captured before clear", d, 50);

      // R7 overflow, R8 write-one clear
      wr(4'd0, 16'h0000);
      wr(4'd5, 16'hffff);
      wr(4'd10, 16'h1f);
      pulse(0, 1);
      rd(4'd5, d);  check("R7 wrap count", d, 0);
      rd(4'd10, d); check("R7 overflow flag", d, 16'h10);
      wr(4'd10, 16'h0000);
      rd(4'd10, d); check("R8 zero write keeps", d, 16'h10);
      wr(4'd10, 16'h0010);
      rd(4'd10, d); check("R8 one write clears", d, 0);

      done = 1'b1;
      finish_run();
   end
endmodule